// File: doc/BRIEF.md
# Page Hamming ECC Accumulator

This block forms a single-error-correcting Hamming parity over fixed-size segments of a NAND page while the bytes stream through. It works the same way for program data on its way out and for read data on its way in. Each byte that is accepted adds two kinds of parity to the running value. Column parity groups the bit positions inside the byte. Line parity groups the position of the byte inside its segment.

When the last byte of a segment is accepted, the block latches the finished parity as a result word. It also latches the packed form that the spare area stores, raises a one-cycle done pulse and starts the next segment from zero without needing a clear. A clear strobe aborts the segment in progress. An enable gates whether streamed bytes count at all.

The result is ready in the cycle after the closing byte, so read-back software has to wait one cycle after the last byte. Locating and correcting a flipped bit is left to the consumer: it XORs the stored and recomputed results.

Top module: `hecc_page_acc`

## Requirements
- R1: After reset, `res_word` is 0, `ecc_stored` is 0xFFFFFF and `seg_done` is low.
- R2: A byte is accepted only in a cycle where both `in_valid` and `ecc_en` are high. In any other cycle the byte changes neither the parity nor the byte position.
- R3: Result bits 5:0 hold column parity. Bit 2j+1 is the XOR of every accepted data bit whose bit position n has bit j of n set. Bit 2j is the XOR of those with bit j of n clear (j = 0..2).
- R4: Result bits 21:6 hold line parity. With p the XOR of all bits of a byte and i its index in the segment (0..255), result bit 6+2k+1 is the XOR of p over bytes with bit k of i set, and result bit 6+2k is the XOR over bytes with bit k of i clear (k = 0..7).
- R5: `seg_done` is high for exactly one cycle, the cycle after the 256th byte of a segment is accepted. `res_word` and `ecc_stored` take the new segment's values in that same cycle and hold them at all other times.
- R6: The byte accepted after a segment closes is index 0 of a new segment whose parity starts from zero. No clear is needed between segments.
- R7: `ecc_clr` discards the partial parity and resets the byte position. A byte accepted in the same cycle as `ecc_clr` becomes index 0 of the fresh segment. A clear that coincides with what would have been the 256th byte therefore produces no `seg_done`.
- R8: `ecc_stored` equals the bitwise inverse of `res_word` shifted left by two, kept to 24 bits. Byte 0 of the stored form (bits 23:16) comes first, then bits 15:8, then bits 7:0.
- R9: Flipping one data bit b of byte i changes the result in exactly these bits: bit 2j + b[j] for j = 0..2, and bit 6+2k+i[k] for k = 0..7. This difference pattern is unique for every (i, b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_clr | input | 1 | Clear strobe: restart the current segment |
| ecc_en | input | 1 | Accumulation enable |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_byte | input | 8 | Streamed page byte |
| res_word | output | 22 | Latched parity of the last finished segment |
| ecc_stored | output | 24 | Packed, inverted spare-area form, byte 0 in the top bits |
| seg_done | output | 1 | One-cycle pulse after a segment's last byte |

## Verification
Two things can fall in the same cycle: a clear and the acceptance of a byte. The bench provokes this in two places. The first is in the middle of a segment, where the coinciding byte must count as index 0 of a fresh segment. The second is on the byte that would have closed the segment, where no done pulse may appear and the segment must close only after a further 255 bytes. Both cases are judged against parity computed arithmetically in the bench, and the done pulse is watched on every cycle for early firing.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int BYTE_W = 8;
  localparam int BITPOS_W = $clog2(BYTE_W);
  localparam int COL_W = 2 * BITPOS_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0] col_t;
endpackage

// File: rtl/hecc_col_terms.sv
module hecc_col_terms
  import hecc_pkg::*;
(
  input  byte_t data,
  output col_t  terms,
  output logic  byte_par
);
  // Each bit position n feeds the odd term of pair j when n[j] is set,
  // and the even term otherwise.
  always_comb begin
    terms = '0;
    for (int n = 0; n < BYTE_W; n++) begin
      for (int j = 0; j < BITPOS_W; j++) begin
        if (n[j]) terms[2*j+1] = terms[2*j+1] ^ data[n];
        else      terms[2*j]   = terms[2*j]   ^ data[n];
      end
    end
  end

  assign byte_par = ^data;
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
  import hecc_pkg::*;
#(
  parameter int SEG_BYTES = 256,
  localparam int IDX_W = $clog2(SEG_BYTES),
  localparam int LINE_W = 2 * IDX_W,
  localparam int RES_W = COL_W + LINE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  byte_t            data,
  output logic             seg_end,
  output logic [RES_W-1:0] seg_word
);
  logic [IDX_W-1:0]  cnt;
  col_t              acc_col;
  logic [LINE_W-1:0] acc_line;

  logic [IDX_W-1:0]  idx;
  col_t              base_col, col_terms, sum_col;
  logic [LINE_W-1:0] base_line, line_hit, sum_line;
  logic              byte_par;

  hecc_col_terms u_col (
    .data     (data),
    .terms    (col_terms),
    .byte_par (byte_par)
  );

  // A clear in the same cycle makes this byte index 0 of a fresh segment.
  assign idx       = clr ? '0 : cnt;
  assign base_col  = clr ? '0 : acc_col;
  assign base_line = clr ? '0 : acc_line;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign line_hit[2*k+1] = take & byte_par &  idx[k];
    assign line_hit[2*k]   = take & byte_par & ~idx[k];
  end

  assign sum_col  = base_col ^ (take ? col_terms : '0);
  assign sum_line = base_line ^ line_hit;
  assign seg_end  = take && (idx == IDX_W'(SEG_BYTES - 1));
  assign seg_word = {sum_line, sum_col};

  always_ff @(posedge clk) begin
    if (rst || seg_end) begin
      cnt      <= '0;
      acc_col  <= '0;
      acc_line <= '0;
    end else begin
      cnt      <= take ? idx + 1'b1 : idx;
      acc_col  <= sum_col;
      acc_line <= sum_line;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clr && !take) |=> (cnt == '0 && acc_col == '0 && acc_line == '0)); // R7
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !take) |=> ($stable(cnt) && $stable(acc_col) && $stable(acc_line))); // R2
endmodule

// File: rtl/hecc_pack.sv
module hecc_pack #(
  parameter int RES_W = 22,
  localparam int STORE_BYTES = (RES_W + 2 + 7) / 8,
  localparam int STORE_W = 8 * STORE_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [RES_W-1:0]   word,
  output logic [STORE_W-1:0] stored
);
  logic [STORE_W-1:0] shifted;

  always_comb begin
    shifted = '0;
    shifted[RES_W+1:0] = {word, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst)       stored <= '1;
    else if (load) stored <= ~shifted;
  end
endmodule

// File: rtl/hecc_page_acc.sv
module hecc_page_acc
  import hecc_pkg::*;
#(
  parameter int SEG_BYTES = 256,
  localparam int IDX_W = $clog2(SEG_BYTES),
  localparam int RES_W = COL_W + 2 * IDX_W,
  localparam int STORE_W = 8 * ((RES_W + 2 + 7) / 8)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ecc_clr,
  input  logic               ecc_en,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic [RES_W-1:0]   res_word,
  output logic [STORE_W-1:0] ecc_stored,
  output logic               seg_done
);
  logic             take, seg_end;
  logic [RES_W-1:0] seg_word;

  assign take = in_valid & ecc_en;

  hecc_accum #(.SEG_BYTES(SEG_BYTES)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (ecc_clr),
    .take     (take),
    .data     (in_byte),
    .seg_end  (seg_end),
    .seg_word (seg_word)
  );

  hecc_pack #(.RES_W(RES_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .load   (seg_end),
    .word   (seg_word),
    .stored (ecc_stored)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_word <= '0;
      seg_done <= 1'b0;
    end else begin
      seg_done <= seg_end;
      if (seg_end) res_word <= seg_word;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    seg_done |=> !seg_done); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !seg_done |-> $stable(res_word)); // R5
  AST_STORED_FORM: assert property (@(posedge clk) disable iff (rst)
    seg_done |-> (ecc_stored == ~(STORE_W'({res_word, 2'b00})))); // R8
  AST_STORED_HELD: assert property (@(posedge clk) disable iff (rst)
    !seg_done |-> $stable(ecc_stored)); // R5
endmodule

// File: tb/hecc_page_acc_tb.sv
module hecc_page_acc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ecc_clr = 1'b0, ecc_en = 1'b0, in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [21:0] res_word;
  logic [23:0] ecc_stored;
  logic        seg_done;

  int checks = 0;
  int errors = 0;
  int early = 0;
  logic [7:0]  seg [256];
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  hecc_page_acc u_dut (
    .clk(clk), .rst(rst), .ecc_clr(ecc_clr), .ecc_en(ecc_en),
    .in_valid(in_valid), .in_byte(in_byte),
    .res_word(res_word), .ecc_stored(ecc_stored), .seg_done(seg_done)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[7:0];
  endfunction

  // Parity of the 256 bytes in seg, built from R3 and R4.
  function automatic logic [21:0] model();
    logic [21:0] w = '0;
    for (int i = 0; i < 256; i++) begin
      for (int n = 0; n < 8; n++)
        if (seg[i][n])
          for (int j = 0; j < 3; j++) w[2*j + n[j]] ^= 1'b1;
      for (int k = 0; k < 8; k++) w[6 + 2*k + i[k]] ^= ^seg[i];
    end
    return w;
  endfunction

  function automatic logic [23:0] pack(input logic [21:0] w);
    return ~{w, 2'b00};
  endfunction

  task automatic put(input logic [7:0] b, input logic v, input logic e, input logic c);
    in_byte = b; in_valid = v; ecc_en = e; ecc_clr = c;
    @(negedge clk);
    in_valid = 1'b0; ecc_en = 1'b0; ecc_clr = 1'b0;
  endtask

  task automatic feed(input int from, input int to);
    for (int i = from; i <= to; i++) begin
      put(seg[i], 1'b1, 1'b1, 1'b0);
      if (i != 255 && seg_done) early++;
    end
  endtask

  task automatic end_check(input string rq);
    logic [21:0] w = model();
    check({rq, " done pulse"}, {31'd0, seg_done}, 32'd1);
    check({rq, " result"}, {10'd0, res_word}, {10'd0, w});
    check({"R8 stored"}, {8'd0, ecc_stored}, {8'd0, pack(w)});
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) seg[i] = rnd8();
  endtask

  initial begin
    #(20ns * 190000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [21:0] base, hold, dexp;
    logic [7:0]  x;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 result", {10'd0, res_word}, 32'd0);
    check("R1 stored", {8'd0, ecc_stored}, 32'h00FF_FFFF);
    check("R1 done", {31'd0, seg_done}, 32'd0);

    // R3 R4 all zero segment
    for (int i = 0; i < 256; i++) seg[i] = 8'h00;
    feed(0, 255); end_check("R4 zeros");

    // R3 R4 R8 single byte 0x01 at index 0, hand value
    seg[0] = 8'h01;
    feed(0, 255);
    check("R3 single col/line", {10'd0, res_word}, 32'h0015_5555);
    check("R8 byte0", {24'd0, ecc_stored[23:16]}, 32'hAA);
    check("R8 byte1", {24'd0, ecc_stored[15:8]}, 32'hAA);
    check("R8 byte2", {24'd0, ecc_stored[7:0]}, 32'hAB);

    // R3 R4 ramp
    for (int i = 0; i < 256; i++) seg[i] = i[7:0];
    feed(0, 255); end_check("R3 ramp");

    // R6 back-to-back random segments, R5 pulse width and hold
    for (int s = 0; s < 3; s++) begin
      fill_random();
      feed(0, 255); end_check("R6 back-to-back");
    end
    hold = res_word;
    put(8'h00, 1'b0, 1'b0, 1'b0);
    check("R5 done falls", {31'd0, seg_done}, 32'd0);
    repeat (4) put(8'h00, 1'b0, 1'b0, 1'b0);
    check("R5 result held", {10'd0, res_word}, {10'd0, hold});

    // R9 single-bit flips
    fill_random();
    feed(0, 255); end_check("R9 base");
    base = res_word;
    for (int t = 0; t < 6; t++) begin
      int ii;
      case (t)
        0: ii = 0;   1: ii = 1;   2: ii = 37;
        3: ii = 127; 4: ii = 128; default: ii = 255;
      endcase
      for (int b = 0; b < 8; b++) begin
        seg[ii] ^= 8'(1 << b);
        feed(0, 255);
        dexp = '0;
        for (int j = 0; j < 3; j++) dexp[2*j + b[j]] = 1'b1;
        for (int k = 0; k < 8; k++) dexp[6 + 2*k + ii[k]] = 1'b1;
        check("R9 flip syndrome", {10'd0, res_word ^ base}, {10'd0, dexp});
        seg[ii] ^= 8'(1 << b);
      end
    end

    // R2 gaps: valid without enable, enable without valid
    fill_random();
    hold = res_word;
    feed(0, 99);
    for (int g = 0; g < 10; g++) put(rnd8(), 1'b1, 1'b0, 1'b0);
    for (int g = 0; g < 10; g++) put(rnd8(), 1'b0, 1'b1, 1'b0);
    check("R2 gap no done", {31'd0, seg_done}, 32'd0);
    check("R2 gap result held", {10'd0, res_word}, {10'd0, hold});
    feed(100, 255); end_check("R2 gated");

    // R7 clear without a byte in mid-segment
    fill_random();
    feed(0, 99);
    put(8'h5A, 1'b0, 1'b1, 1'b1);
    feed(0, 255); end_check("R7 idle clear");

    // R7 clear together with an accepted byte
    fill_random();
    feed(0, 49);
    put(seg[0], 1'b1, 1'b1, 1'b1);
    feed(1, 255); end_check("R7 clear with byte");

    // R7 clear on the would-be closing byte
    fill_random();
    feed(0, 254);
    x = rnd8();
    put(x, 1'b1, 1'b1, 1'b1);
    check("R7 no done on cleared last", {31'd0, seg_done}, 32'd0);
    seg[0] = x;
    feed(1, 255); end_check("R7 cleared last");

    check("R5 no early done", early, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule